// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Queue

This block lets cores of a multi-core cluster signal each other with small interrupt numbers. Each core owns a first-in, first-out queue of pending numbers and one interrupt line. A core posts a number by writing a send register. The write names a target core and picks one of two delivery modes: the number goes either to that core alone or to every core except that one. The receiving core reads its acknowledge register to take the oldest pending number. Its interrupt line stays high until its queue is empty again.

Access is through a simple single-cycle register bus. The accessing core's index travels with every access as a sideband field, so all cores share one acknowledge offset and each one reaches its own queue there. Each queue is driven by a small state machine with three states. Q_EMPTY means no entries. Q_PENDING means some entries, but not a full queue. Q_FULL means the queue holds DEPTH entries.

The state machine has these transitions. Q_EMPTY goes to Q_PENDING on an accepted post, or straight to Q_FULL when DEPTH is 1. Q_PENDING goes to Q_FULL when a post fills the last slot. Q_PENDING goes to Q_EMPTY when the last entry is popped. Q_FULL goes to Q_PENDING on a pop. A flush takes any state to Q_EMPTY. A post that arrives in Q_FULL without a matching pop is dropped, and the queue stays in Q_FULL.

Top module: `ipi_queue_ctrl`

## Requirements
- R1: A send write carries the target core index in bus_wdata[15:0] and the interrupt number in bus_wdata[31:16]. The core index is compared over all 16 bits.
- R2: A write to offset 0 (unicast send) appends the number to the tail of the named core's queue. No other queue changes.
- R3: A write to offset 1 (broadcast send) appends the number to the queue of every core except the named one. An index of NCORES or more reaches all cores.
- R4: An accepted post raises that core's irq bit on the clock edge that samples the write.
- R5: A read of offset 2 (acknowledge) by core c returns the head of c's queue in rd_data[15:0], with upper bits zero. The data is valid after the sampling edge. The entry is removed, so numbers come out in posting order.
- R6: An acknowledge read with an empty queue returns 0 and changes no state.
- R7: A write to offset 2 discards every entry of the accessing core's queue and clears its overflow flag. Its irq drops on the sampling edge. Other cores are untouched.
- R8: A core's irq stays high while its queue holds entries. It drops on the edge of the read that removes the last entry.
- R9: A post to a full queue (DEPTH entries, default 8) is dropped. The queue's contents stay intact, and that core's ovf bit is set. ovf stays set until the core writes offset 2 or reset is applied.
- R10: After reset, all queues are empty, irq and ovf are all zero, and rd_data is 0.
- R11: Reads of offsets 0, 1 and 3 return 0 and pop nothing. Writes to offset 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CORE_W (2) | Index of the accessing core |
| rd_data | output | 32 | Registered read data |
| irq | output | NCORES (4) | Per-core interrupt line |
| ovf | output | NCORES (4) | Per-core sticky overflow flag |

## Verification
Every result is due on the first rising edge after the access is driven. This applies to the queue contents, the irq and ovf bits, and rd_data. The bench changes inputs on falling edges and holds each access for one cycle. The read monitor compares rd_data at the falling edge after the sampling edge, against the value the driver queued from its reference model. The flag checks run at that same falling edge, so no check looks at a value in the cycle it changes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int IDX_W  = 16;
    localparam int DATA_W = 32;
    localparam int NUM_W  = DATA_W - IDX_W;

    typedef enum logic [1:0] {
        REG_SEND_ONE    = 2'd0,
        REG_SEND_OTHERS = 2'd1,
        REG_ACK         = 2'd2,
        REG_SPARE       = 2'd3
    } reg_off_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PENDING = 2'd1,
        Q_FULL    = 2'd2
    } q_state_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int CORE_W = 2
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [IDX_W-1:0]  target_idx,
    input  logic [CORE_W-1:0] bus_core,
    output logic [NCORES-1:0] post_v,
    output logic [NCORES-1:0] pop_v,
    output logic [NCORES-1:0] flush_v
);

    logic wr_one, wr_others, rd_ack, wr_ack;

    always_comb begin
        wr_one    = bus_en && bus_we  && (bus_addr == REG_SEND_ONE);
        wr_others = bus_en && bus_we  && (bus_addr == REG_SEND_OTHERS);
        rd_ack    = bus_en && !bus_we && (bus_addr == REG_ACK);
        wr_ack    = bus_en && bus_we  && (bus_addr == REG_ACK);
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic named, mine;
        assign named      = (target_idx == IDX_W'(c));
        assign mine       = (bus_core == CORE_W'(c));
        assign post_v[c]  = (wr_one && named) || (wr_others && !named);
        assign pop_v[c]   = rd_ack && mine;
        assign flush_v[c] = wr_ack && mine;
    end

endmodule

// File: rtl/ipi_core_queue.sv
module ipi_core_queue
    import ipi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int QNUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [QNUM_W-1:0] push_num,
    input  logic              pop,
    input  logic              flush,
    output logic [QNUM_W-1:0] head_num,
    output logic              irq_o,
    output logic              ovf_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    q_state_t          state, state_nxt;
    logic [QNUM_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count, cnt_nxt;
    logic              push_ok, pop_ok, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok  = pop && (state != Q_EMPTY);
        push_ok = push && ((state != Q_FULL) || pop_ok);
        drop    = push && !push_ok;
        cnt_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        head_num = (state == Q_EMPTY) ? '0 : mem[rd_ptr];
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (!flush && push_ok)
                    state_nxt = (DEPTH == 1) ? Q_FULL : Q_PENDING;
            end
            Q_PENDING: begin
                if (flush || cnt_nxt == '0)
                    state_nxt = Q_EMPTY;
                else if (cnt_nxt == CNT_W'(DEPTH))
                    state_nxt = Q_FULL;
            end
            Q_FULL: begin
                if (flush)
                    state_nxt = Q_EMPTY;
                else if (pop_ok && !push_ok)
                    state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PENDING;
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            ovf_o <= 1'b0;
        end else begin
            irq_o <= (state_nxt != Q_EMPTY);
            if (flush)     ovf_o <= 1'b0;
            else if (drop) ovf_o <= 1'b1;
        end
    end

    // storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_num;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            count <= cnt_nxt;
        end
    end

    a_r4_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> irq_o);
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!irq_o && !ovf_o));
    a_r9_full_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && state == Q_FULL) |=> ovf_o);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flush) |=> ovf_o);
    a_r8_irq_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (count != '0));
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/ipi_queue_ctrl.sv
module ipi_queue_ctrl
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int DEPTH  = 8,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CORE_W-1:0] bus_core,
    output logic [31:0]       rd_data,
    output logic [NCORES-1:0] irq,
    output logic [NCORES-1:0] ovf
);

    logic [NCORES-1:0] post_v, pop_v, flush_v;
    logic [NUM_W-1:0]  heads [NCORES];
    logic [NUM_W-1:0]  sel_head;
    logic              core_ok;

    ipi_decode #(.NCORES(NCORES), .CORE_W(CORE_W)) u_dec (
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .target_idx (bus_wdata[IDX_W-1:0]),
        .bus_core   (bus_core),
        .post_v     (post_v),
        .pop_v      (pop_v),
        .flush_v    (flush_v)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_q
        ipi_core_queue #(.DEPTH(DEPTH), .QNUM_W(NUM_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (post_v[c]),
            .push_num (bus_wdata[DATA_W-1:IDX_W]),
            .pop      (pop_v[c]),
            .flush    (flush_v[c]),
            .head_num (heads[c]),
            .irq_o    (irq[c]),
            .ovf_o    (ovf[c])
        );
    end

    always_comb begin
        core_ok  = (32'(bus_core) < NCORES);
        sel_head = '0;
        for (int c = 0; c < NCORES; c++)
            if (bus_core == CORE_W'(c)) sel_head = heads[c];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (bus_en && !bus_we)
            rd_data <= (bus_addr == REG_ACK && core_ok) ? 32'(sel_head) : '0;
    end

    a_r11_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_v));
    a_r7_flush_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_v));
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == REG_ACK && core_ok && !irq[bus_core])
        |=> (rd_data == '0));
    a_r11_send_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr != REG_ACK) |=> (rd_data == '0));

endmodule

// File: tb/ipi_queue_ctrl_test.sv
module ipi_queue_ctrl_test;

    localparam int NC = 4;
    localparam int DP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_core = '0;
    logic [31:0] rd_data;
    logic [NC-1:0] irq, ovf;

    ipi_queue_ctrl #(.NCORES(NC), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
        .rd_data(rd_data), .irq(irq), .ovf(ovf)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int unsigned mq [NC][$];
    bit [NC-1:0] ovf_m = '0;
    int unsigned exp_q [$];
    string tag_q [$];
    bit rd_flag = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input bit we, input int addr, input logic [31:0] data, input int core);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = addr[1:0];
        bus_wdata = data; bus_core = core[1:0];
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [NC-1:0] irq_model();
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = (mq[c].size() > 0);
        return v;
    endfunction

    task automatic check_flags(input string tag);
        check(irq === irq_model(), {tag, " irq"}, irq, irq_model());
        check(ovf === ovf_m, {tag, " ovf"}, ovf, ovf_m);
    endtask

    task automatic post(input bit others, input int idx, input int num, input string tag);
        for (int c = 0; c < NC; c++) begin
            bit hit = others ? (c != idx) : (c == idx);
            if (hit) begin
                if (mq[c].size() < DP) mq[c].push_back(num);
                else ovf_m[c] = 1'b1;
            end
        end
        bus_op(1'b1, others ? 1 : 0, {num[15:0], idx[15:0]}, 0);
        check_flags(tag);
    endtask

    task automatic rd(input int core, input int addr, input string tag);
        int unsigned e = 0;
        if (addr == 2 && mq[core].size() > 0) e = mq[core].pop_front();
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_op(1'b0, addr, 32'h0, core);
        check_flags(tag);
    endtask

    task automatic ack_wr(input int core, input string tag);
        mq[core].delete();
        ovf_m[core] = 1'b0;
        bus_op(1'b1, 2, 32'h0, core);
        check_flags(tag);
    endtask

    // monitor: records a read on the sampling edge, compares on the next falling edge
    always @(posedge clk) rd_flag <= rst_n && bus_en && !bus_we;

    always @(negedge clk) begin
        if (rd_flag) begin
            int unsigned e;
            string t;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD;
            t = (tag_q.size() > 0) ? tag_q.pop_front() : "unexpected read";
            check(rd_data === e, {t, " rd_data"}, rd_data, e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(rd_data === 0, "R10 rd_data", rd_data, 0);
        check(irq === 0, "R10 irq", irq, 0);
        check(ovf === 0, "R10 ovf", ovf, 0);

        post(1'b0, 1, 16'h0011, "R2 unicast core1");
        post(1'b1, 2, 16'h0022, "R3 all-but core2");
        post(1'b1, 7, 16'h0033, "R3 index beyond cores");
        post(1'b0, 32'h0102, 16'h0044, "R1 index upper bits");
        post(1'b0, 2, 16'hABCD, "R4 unicast core2");

        rd(1, 2, "R5 core1 first");
        rd(1, 2, "R5 core1 second");
        rd(1, 2, "R8 core1 last");
        rd(1, 2, "R6 core1 empty");
        rd(1, 2, "R6 core1 empty again");

        for (int i = 0; i < 6; i++) post(1'b0, 0, 16'h0040 + i, "R9 fill core0");
        post(1'b0, 0, 16'h0099, "R9 overflow core0");
        post(1'b0, 0, 16'h009A, "R9 second overflow");
        for (int i = 0; i < DP; i++) rd(0, 2, "R9 core0 drain order");
        rd(0, 2, "R9 core0 empty after drain");

        rd(2, 0, "R11 read send offset");
        rd(2, 1, "R11 read others offset");
        rd(2, 3, "R11 read spare offset");
        bus_op(1'b1, 3, 32'h0055_0003, 3);
        check_flags("R11 spare write");

        ack_wr(3, "R7 flush core3");
        ack_wr(0, "R7 flush clears ovf core0");
        rd(3, 2, "R7 core3 empty after flush");
        rd(2, 2, "R1 core2 number field");
        rd(2, 2, "R5 core2 second");
        rd(2, 2, "R8 core2 drained");

        post(1'b1, 0, 16'h0077, "R3 all-but core0");
        rd(3, 2, "R5 core3 after broadcast");
        ack_wr(1, "R7 flush core1 only");
        rd(2, 2, "R7 core2 untouched");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule